// File: doc/BRIEF.md
# 32-bit Integer ALU with Shifter

This block is the purely combinational execute unit of a small load/store RISC core. It takes two 32-bit operands, a 5-bit shift count and a 4-bit operation code, and returns a 32-bit result together with a flag that is high when that result is all zeros. A separate branch unit uses the flag to resolve equality branches. To do this, it selects subtraction and tests the flag.

The unit covers the following operations:

- wrapping add and subtract;
- bitwise AND, OR and NOR;
- signed set-on-less-than;
- a logical left shift by a count taken from the instruction;
- placement of a 16-bit immediate in the upper half of the word.

Choosing between registers, sign-extended immediates and zero-extended immediates happens before this block. It has no clock, no state and no reset. The result settles within the same cycle as its inputs.

Top module: `alu_core`

## Requirements
- R1: With op_sel = 4'h0, result is the sum opnd_a + opnd_b.
- R2: With op_sel = 4'h1, result is opnd_a - opnd_b.
- R3: Add and subtract wrap modulo 2^32 and have no overflow output. For example, 0xFFFFFFFF + 1 gives 0, and 0 - 1 gives 0xFFFFFFFF.
- R4: With op_sel = 4'h2, result is the bitwise AND of the operands. With op_sel = 4'h3, it is the bitwise OR.
- R5: With op_sel = 4'h4, result is ~(opnd_a | opnd_b). When one operand is zero, this inverts the other.
- R6: With op_sel = 4'h5, result is 32'd1 when opnd_a < opnd_b as signed two's-complement values, and 32'd0 otherwise. This holds when the operand signs differ.
- R7: With op_sel = 4'h6, result is opnd_b shifted left by shamt, with zero fill. For example, 0x9 shifted by 4 gives 0x90.
- R8: With op_sel = 4'h7, result[31:16] = opnd_b[15:0] and result[15:0] = 0. For example, an immediate of 255 gives 0x00FF0000.
- R9: zero is 1 exactly when result is all zeros.
- R10: Codes 4'h8 to 4'hF drive result to 0, so zero reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand; shift source and immediate source |
| shamt | input | 5 | Left-shift count |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The assertions are immediate checks that are evaluated whenever the inputs change. They assume that every input is a settled two-state value that does not change within one evaluation, and that shamt is meaningful only under the shift code. The stimulus meets these assumptions in two ways:

- It changes all inputs together, once per cycle, just after a rising edge.
- It samples at the falling edge.

The stimulus also exercises operands of mixed sign, wrapping sums, and every unused code.

// File: rtl/alu_pkg.sv
// Package: shared operation codes and widths for the ALU.
// Assumes a 4-bit operation code; codes 8..15 are unused.
package alu_pkg;
    localparam int ALU_W   = 32;
    localparam int OP_W    = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'h0,
        OP_SUB = 4'h1,
        OP_AND = 4'h2,
        OP_OR  = 4'h3,
        OP_NOR = 4'h4,
        OP_SLT = 4'h5,
        OP_SLL = 4'h6,
        OP_LUI = 4'h7
    } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
// Module: one shared adder for add, subtract and signed less-than.
// Assumes the caller asserts do_sub for both subtract and compare.
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             do_sub,
    output logic [WIDTH-1:0] sum,
    output logic             lt_signed
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;

    // Invert b and inject a carry to form a - b on the same adder.
    always_comb begin
        b_eff = do_sub ? ~b : b;
        sum   = a + b_eff + WIDTH'(do_sub);
    end

    // Signed compare: on a sign mismatch the sign of a decides, otherwise the difference sign.
    always_comb begin
        if (a[MSB] != b[MSB])
            lt_signed = a[MSB];
        else
            lt_signed = sum[MSB];
    end
endmodule

// File: rtl/alu_logic.sv
// Module: bitwise AND, OR and NOR of two operands.
// Assumes nothing beyond equal operand widths.
module alu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] nor_o
);
    // Produce all three bitwise results in parallel.
    always_comb begin
        and_o = a & b;
        or_o  = a | b;
        nor_o = ~(a | b);
    end
endmodule

// File: rtl/alu_shift.sv
// Module: logarithmic left shifter plus upper-half immediate placement.
// Assumes WIDTH is a power of two and even.
module alu_shift #(
    parameter int WIDTH = 32,
    localparam int SH_W = $clog2(WIDTH),
    localparam int HALF = WIDTH / 2
) (
    input  logic [WIDTH-1:0] src,
    input  logic [SH_W-1:0]  amount,
    input  logic [HALF-1:0]  imm,
    output logic [WIDTH-1:0] shl_o,
    output logic [WIDTH-1:0] upper_o
);
    logic [WIDTH-1:0] stage [SH_W+1];

    assign stage[0] = src;

    // One stage per count bit, each moving by a power of two.
    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        always_comb begin
            stage[i+1] = amount[i] ? (stage[i] << (1 << i)) : stage[i];
        end
    end

    // Route the final stage out and build the upper-half constant.
    always_comb begin
        shl_o   = stage[SH_W];
        upper_o = {imm, {HALF{1'b0}}};
    end
endmodule

// File: rtl/alu_core.sv
// Module: top of the combinational ALU; picks one unit result by op_sel.
// Assumes operand selection happens upstream; no clock or reset is needed.
module alu_core
    import alu_pkg::*;
(
    input  logic [3:0]  op_sel,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic [4:0]  shamt,
    output logic [31:0] result,
    output logic        zero
);
    localparam int WIDTH = ALU_W;
    localparam int HALF  = WIDTH / 2;

    logic             use_sub;
    logic [WIDTH-1:0] sum;
    logic             lt;
    logic [WIDTH-1:0] and_r, or_r, nor_r, shl_r, upper_r;

    // Request subtraction for both subtract and compare.
    always_comb begin
        use_sub = (op_sel == OP_SUB) || (op_sel == OP_SLT);
    end

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a(opnd_a), .b(opnd_b), .do_sub(use_sub),
        .sum(sum), .lt_signed(lt)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a(opnd_a), .b(opnd_b),
        .and_o(and_r), .or_o(or_r), .nor_o(nor_r)
    );

    alu_shift #(.WIDTH(WIDTH)) u_shift (
        .src(opnd_b), .amount(shamt), .imm(opnd_b[HALF-1:0]),
        .shl_o(shl_r), .upper_o(upper_r)
    );

    // Select the result of the requested operation; unused codes give zero.
    always_comb begin
        case (op_sel)
            OP_ADD, OP_SUB: result = sum;
            OP_AND:         result = and_r;
            OP_OR:          result = or_r;
            OP_NOR:         result = nor_r;
            OP_SLT:         result = {{(WIDTH-1){1'b0}}, lt};
            OP_SLL:         result = shl_r;
            OP_LUI:         result = upper_r;
            default:        result = '0;
        endcase
    end

    // Flag an all-zero result for the branch unit.
    always_comb begin
        zero = ~|result;
    end
endmodule

// File: rtl/alu_core_chk.sv
// Module: property checker for alu_core, bound to every instance.
// Assumes settled two-state inputs; uses immediate checks since the block has no clock.
module alu_core_chk (
    input logic [3:0]  op_sel,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic [4:0]  shamt,
    input logic [31:0] result,
    input logic        zero
);
    // Relate outputs to inputs for each operation class.
    always_comb begin
        if (op_sel == 4'h5)
            p_slt_binary_r6: assert ($countones(result[31:1]) == 0);
        if (op_sel == 4'h7)
            p_upper_low_clear_r8: assert (result[15:0] == 16'h0 && result[31:16] == opnd_b[15:0]);
        if (op_sel == 4'h6)
            p_shift_fill_r7: assert ((result & ((32'd1 << shamt) - 32'd1)) == 32'd0);
        if (op_sel == 4'h4)
            p_nor_disjoint_r5: assert ((result & (opnd_a | opnd_b)) == 32'd0);
        if (op_sel == 4'h2)
            p_and_subset_r4: assert ((result & ~opnd_a) == 32'd0);
        if (op_sel == 4'h1 && opnd_a == opnd_b)
            p_sub_equal_zero_r2: assert (zero);
        if (op_sel[3])
            p_unused_zero_r10: assert (zero && result == 32'd0);
        if (zero)
            p_zero_result_r9: assert (result == 32'd0);
    end
endmodule

bind alu_core alu_core_chk u_chk (.*);

// File: tb/alu_core_test.sv
module alu_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  shamt  = '0;
    logic [31:0] result;
    logic        zero;

    typedef struct {
        logic [31:0] exp_res;
        logic        exp_zero;
        string       req;
    } item_t;

    item_t sb_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;

    always #4 clk = ~clk;

    alu_core uut (
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .shamt(shamt), .result(result), .zero(zero)
    );

    function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [4:0] s);
        case (op)
            4'h0: return a + b;
            4'h1: return a - b;
            4'h2: return a & b;
            4'h3: return a | b;
            4'h4: return ~(a | b);
            4'h5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'h6: return b << s;
            4'h7: return {b[15:0], 16'h0};
            default: return 32'd0;
        endcase
    endfunction

    // Driver: apply one vector after a rising edge and queue its expectation.
    task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] s, input logic [31:0] exp, input string req);
        item_t it;
        @(posedge clk);
        #1;
        op_sel = op; opnd_a = a; opnd_b = b; shamt = s;
        it.exp_res  = exp;
        it.exp_zero = (exp == 32'd0);
        it.req      = req;
        sb_q.push_back(it);
    endtask

    task automatic drive_m(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                           input logic [4:0] s, input string req);
        drive(op, a, b, s, model(op, a, b, s), req);
    endtask

    // Monitor: compare settled outputs at each falling edge against the queue head.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (result !== it.exp_res) begin
                    n_fail++;
                    $display("FAIL %s result actual=%h expected=%h", it.req, result, it.exp_res);
                end
                n_checks++;
                if (zero !== it.exp_zero) begin
                    n_fail++;
                    $display("FAIL R9 (%s) zero actual=%b expected=%b", it.req, zero, it.exp_zero);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: all-zero inputs under add give zero (R1, R9).
        drive(4'h0, 32'h0, 32'h0, 5'd0, 32'h0, "R1 reset");
        drive(4'h0, 32'd7, 32'd5, 5'd0, 32'd12, "R1");
        drive(4'h0, 32'h1234_5678, 32'h1111_1111, 5'd0, 32'h2345_6789, "R1");
        drive(4'h1, 32'd20, 32'd7, 5'd0, 32'd13, "R2");
        drive(4'h1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'd0, 32'd0, "R2 equal");
        drive(4'h0, 32'hFFFF_FFFF, 32'd1, 5'd0, 32'd0, "R3 wrap add");
        drive(4'h1, 32'd0, 32'd1, 5'd0, 32'hFFFF_FFFF, "R3 wrap sub");
        drive(4'h0, 32'h7FFF_FFFF, 32'd1, 5'd0, 32'h8000_0000, "R3 signed wrap");
        drive(4'h2, 32'h0000_3C00, 32'h0000_0D00, 5'd0, 32'h0000_0C00, "R4 and");
        drive(4'h3, 32'h0000_3C00, 32'h0000_0D00, 5'd0, 32'h0000_3D00, "R4 or");
        drive(4'h4, 32'h0000_3C00, 32'h0, 5'd0, 32'hFFFF_C3FF, "R5 nor invert");
        drive(4'h4, 32'hFFFF_0000, 32'h0000_FFFF, 5'd0, 32'h0, "R5 nor full");
        drive(4'h5, 32'd3, 32'd9, 5'd0, 32'd1, "R6 less");
        drive(4'h5, 32'd9, 32'd3, 5'd0, 32'd0, "R6 greater");
        drive(4'h5, 32'd4, 32'd4, 5'd0, 32'd0, "R6 equal");
        drive(4'h5, 32'hFFFF_FFFF, 32'd1, 5'd0, 32'd1, "R6 neg<pos");
        drive(4'h5, 32'd1, 32'h8000_0000, 5'd0, 32'd0, "R6 pos>min");
        drive(4'h5, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 32'd1, "R6 min<max");
        drive(4'h6, 32'h0, 32'h9, 5'd4, 32'h90, "R7 example");
        drive(4'h6, 32'h0, 32'hFFFF_FFFF, 5'd31, 32'h8000_0000, "R7 max shift");
        drive(4'h6, 32'h0, 32'hA5A5_A5A5, 5'd0, 32'hA5A5_A5A5, "R7 zero shift");
        drive(4'h7, 32'h0, 32'd255, 5'd0, 32'h00FF_0000, "R8 example");
        drive(4'h7, 32'hFFFF_FFFF, 32'hABCD_1234, 5'd9, 32'h1234_0000, "R8 upper ignored");
        drive(4'h4, 32'hFFFF_FFFF, 32'h0, 5'd0, 32'h0, "R9 nor zero");
        for (int c = 8; c < 16; c++)
            drive(4'(c), 32'hFFFF_FFFF, 32'h1234_5678, 5'd3, 32'h0, "R10 unused");
        for (int k = 0; k < 64; k++) begin
            logic [31:0] a, b;
            a = 32'h9E37_79B9 * (k + 1);
            b = {a[15:0], a[31:16]} ^ (32'h5555_AAAA >> (k % 7));
            drive_m(4'(k % 8), a, b, 5'(k * 3), "R1-mix");
        end
        repeat (3) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule